// File: doc/BRIEF.md
# SuperSpeed PHY Calibration Write Sequencer

This block runs a fixed three-step tuning program into a PHY's internal register space. It does not write those registers itself. It hands each write to an external control-port master over a simple request interface and waits for that master to report success or failure. A single start pulse launches the program.

The three writes are issued in a fixed order:

1. The receiver loss-detector override.
2. The transmit boost-level override.
3. A lane debug register that holds the receiver-detect measurement time.

The third value depends on the 3-bit reference-clock frequency code, which is captured when the sequence starts.

The program stops at the first write the port master rejects. It then reports which step failed. If all three writes complete, it reports success. A one-cycle done pulse marks the end of every run, successful or not.

Top module: `calseq_top`

## Requirements
- R1: After reset, `wr_req`, `seq_done` and `seq_err` are low and `fail_step` is 0.
- R2: A `start` pulse seen while the sequencer is idle raises `wr_req` in the next cycle, with `wr_addr` = 0x0015 and `wr_data` = 0xA409. In that value, bits 15:13 = 5, bit 10 = 1 and bits 4:0 = 9.
- R3: A `wr_done` on step 1 moves the request to step 2 in the next cycle, with `wr_addr` = 0x0012 and `wr_data` = 0xA000 (bits 15:13 = 5).
- R4: A `wr_done` on step 2 moves the request to step 3, with `wr_addr` = 0x1010 and `wr_data` = M << 4. M is chosen from the frequency code:
  - M = 0x20 for code 7;
  - M = 0x04 for codes 3 and 4;
  - M = 0x08 for every other code.
- R5: The frequency code is sampled only on an accepted start. Changes to `freq_code` during a run do not alter the step-3 value.
- R6: While `wr_req` is high and neither `wr_done` nor `wr_err` is seen, `wr_req`, `wr_addr` and `wr_data` hold their values in the next cycle.
- R7: A `wr_done` on step 3 gives the following in the next cycle:
  - `wr_req` low;
  - `seq_done` high;
  - `seq_err` low;
  - `fail_step` = 0.
- R8: A `wr_err` on step n (n = 1, 2 or 3) gives the following in the next cycle:
  - `wr_req` low, and no later step is requested;
  - `seq_done` and `seq_err` both high;
  - `fail_step` = n, held until the next accepted start.
- R9: A `start` pulse arriving while a run is in progress is ignored: the current step and its values are unchanged.
- R10: An accepted start clears `fail_step` to 0 in the next cycle.
- R11: `seq_done` and `seq_err` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the calibration program when idle |
| freq_code | input | 3 | Reference-clock frequency code |
| wr_req | output | 1 | Write request to the port master |
| wr_addr | output | 16 | Internal PHY register address of the current step |
| wr_data | output | 16 | Value for the current step |
| wr_done | input | 1 | Port master: current write completed |
| wr_err | input | 1 | Port master: current write failed |
| seq_done | output | 1 | One-cycle pulse at the end of a run |
| seq_err | output | 1 | One-cycle pulse at the end of a failed run |
| fail_step | output | 2 | Failed step (1 to 3), 0 if none |

## Verification
The assertions rely on three assumptions about the port master:
- `wr_done` and `wr_err` are never high in the same cycle;
- each is a one-cycle pulse;
- each is given only while `wr_req` is high.

The bench's port-master model follows these rules. It waits a random number of idle cycles before each response, and it draws random stray start pulses and random code changes only in cycles where no response is given. Every frequency code is exercised in both success and failure runs.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int FREQ_W  = 3;
  localparam int STEP_W  = 2;
  localparam int N_STEPS = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Internal register addresses for each step
  function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] step);
    case (step)
      2'd1:    step_addr = ADDR_W'(16'h0015);
      2'd2:    step_addr = ADDR_W'(16'h0012);
      default: step_addr = ADDR_W'(16'h1010);
    endcase
  endfunction

  // Receiver-detect measurement time, selected by the frequency code
  function automatic logic [7:0] meas_time(input logic [FREQ_W-1:0] code);
    case (code)
      3'd7:       meas_time = 8'h20;
      3'd3, 3'd4: meas_time = 8'h04;
      default:    meas_time = 8'h08;
    endcase
  endfunction

  // Loss-detector override: bias field, enable bit and level field
  function automatic logic [DATA_W-1:0] loss_value(input logic [2:0] bias,
                                                   input logic [4:0] level);
    loss_value = (DATA_W'(bias) << 13) | (DATA_W'(1) << 10) | DATA_W'(level);
  endfunction

  // Boost-level override
  function automatic logic [DATA_W-1:0] boost_value(input logic [2:0] lvl);
    boost_value = DATA_W'(lvl) << 13;
  endfunction

endpackage

// File: rtl/calseq_step_table.sv
module calseq_step_table
  import calseq_pkg::*;
#(
  parameter int MEAS_LSB   = 4,
  parameter int LOSS_BIAS  = 5,
  parameter int LOSS_LEVEL = 9,
  parameter int BOOST_LVL  = 5
) (
  input  logic [STEP_W-1:0] step,
  input  logic [FREQ_W-1:0] code,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  localparam logic [DATA_W-1:0] LOSS_WORD  = loss_value(3'(LOSS_BIAS), 5'(LOSS_LEVEL));
  localparam logic [DATA_W-1:0] BOOST_WORD = boost_value(3'(BOOST_LVL));

  always_comb begin
    addr = step_addr(step);
    case (step)
      2'd1:    data = LOSS_WORD;
      2'd2:    data = BOOST_WORD;
      default: data = DATA_W'(meas_time(code)) << MEAS_LSB;
    endcase
  end

endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
  import calseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              running,
  output logic [STEP_W-1:0] step,
  output logic [FREQ_W-1:0] code_q,
  output logic              ev_launch,
  output logic              ev_finish,
  output logic              ev_fail
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS);

  seq_state_e state_q;

  assign running   = (state_q == ST_RUN);
  assign ev_launch = !running && start;
  assign ev_fail   = running && wr_err;
  assign ev_finish = running && wr_done && !wr_err && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step    <= '0;
      code_q  <= '0;
    end else if (ev_launch) begin
      state_q <= ST_RUN;
      step    <= STEP_W'(1);
      code_q  <= freq_code;
    end else if (ev_fail || ev_finish) begin
      state_q <= ST_IDLE;
    end else if (running && wr_done) begin
      step <= step + STEP_W'(1);
    end
  end

  // R9: a start during a run leaves the step untouched
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && !wr_done && !wr_err |=> running && $stable(step) && $stable(code_q));

  // R8: an error ends the run
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_err |=> !running);

  // R3/R4: steps advance one at a time
  a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step != '0));

endmodule

// File: rtl/calseq_status.sv
module calseq_status
  import calseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_launch,
  input  logic              ev_finish,
  input  logic              ev_fail,
  input  logic [STEP_W-1:0] step,
  output logic              seq_done,
  output logic              seq_err,
  output logic [STEP_W-1:0] fail_step
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_done  <= 1'b0;
      seq_err   <= 1'b0;
      fail_step <= '0;
    end else begin
      seq_done <= ev_finish || ev_fail;
      seq_err  <= ev_fail;
      if (ev_launch)    fail_step <= '0;
      else if (ev_fail) fail_step <= step;
    end
  end

  // R11: end-of-run pulses last one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);

  // R8: an error pulse names a step
  a_r8_step_named: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> seq_done && (fail_step != '0));

  // R7: success leaves the failed-step field clear
  a_r7_clean_success: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !seq_err |-> fail_step == '0);

  // R10: a launch clears the failed-step field
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> fail_step == '0);

endmodule

// File: rtl/calseq_top.sv
module calseq_top
  import calseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  freq_code,
  output logic        wr_req,
  output logic [15:0] wr_addr,
  output logic [15:0] wr_data,
  input  logic        wr_done,
  input  logic        wr_err,
  output logic        seq_done,
  output logic        seq_err,
  output logic [1:0]  fail_step
);

  logic              running;
  logic [STEP_W-1:0] step;
  logic [FREQ_W-1:0] code_q;
  logic              ev_launch;
  logic              ev_finish;
  logic              ev_fail;

  calseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .freq_code (freq_code),
    .wr_done   (wr_done),
    .wr_err    (wr_err),
    .running   (running),
    .step      (step),
    .code_q    (code_q),
    .ev_launch (ev_launch),
    .ev_finish (ev_finish),
    .ev_fail   (ev_fail)
  );

  calseq_step_table u_table (
    .step (step),
    .code (code_q),
    .addr (wr_addr),
    .data (wr_data)
  );

  calseq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_launch (ev_launch),
    .ev_finish (ev_finish),
    .ev_fail   (ev_fail),
    .step      (step),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .fail_step (fail_step)
  );

  assign wr_req = running;

  // R6: the request holds steady while no response is given
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done && !wr_err |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R8: no request follows a failed write
  a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_err |=> !wr_req);

  // R2: an idle start raises the request on step 1
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req && start |=> wr_req && (wr_addr == 16'h0015));

  // R7: the end pulse coincides with the request dropping
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !wr_req);

endmodule

// File: tb/tb_calseq_top.sv
module tb_calseq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  freq_code;
  logic        wr_req;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        wr_done;
  logic        wr_err;
  logic        seq_done;
  logic        seq_err;
  logic [1:0]  fail_step;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  calseq_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .freq_code (freq_code),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_done   (wr_done),
    .wr_err    (wr_err),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .fail_step (fail_step)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected < 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input int s);
    if (s == 1)      return 16'h0015;
    else if (s == 2) return 16'h0012;
    else             return 16'h1010;
  endfunction

  function automatic logic [15:0] exp_data(input int s, input logic [2:0] code);
    int m;
    if (s == 1) return 16'hA409;
    if (s == 2) return 16'hA000;
    if (code == 3'd7)                   m = 32;
    else if (code == 3'd3 || code == 3'd4) m = 4;
    else                                m = 8;
    return 16'(m * 16);
  endfunction

  // One run; err_at = 0 for success, else the step to reject.
  task automatic run_seq(input logic [2:0] code, input int err_at, input int max_lat);
    start     = 1'b1;
    freq_code = code;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R10 fail_step cleared", 32'(fail_step), 32'd0);
    check("R2 request raised", 32'(wr_req), 32'd1);

    for (int s = 1; s <= 3; s++) begin
      int lat;
      lat = (max_lat == 0) ? 0 : int'($urandom_range(0, max_lat));
      for (int w = 0; w < lat; w++) begin
        start     = 1'($urandom_range(0, 1));
        freq_code = 3'($urandom);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R6 request held", 32'(wr_req), 32'd1);
        check("R9 stray start ignored", 32'(wr_addr), 32'(exp_addr(s)));
      end

      if (s == 1)      check("R2 step1 addr", 32'(wr_addr), 32'(exp_addr(1)));
      else if (s == 2) check("R3 step2 addr", 32'(wr_addr), 32'(exp_addr(2)));
      else             check("R4 step3 addr", 32'(wr_addr), 32'(exp_addr(3)));

      if (s == 1)      check("R2 step1 data", 32'(wr_data), 32'(exp_data(1, code)));
      else if (s == 2) check("R3 step2 data", 32'(wr_data), 32'(exp_data(2, code)));
      else             check("R4 R5 step3 data", 32'(wr_data), 32'(exp_data(3, code)));

      if (err_at == s) wr_err  = 1'b1;
      else             wr_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_err  = 1'b0;
      wr_done = 1'b0;

      if (err_at == s) begin
        check("R8 request dropped", 32'(wr_req), 32'd0);
        check("R8 done pulse", 32'(seq_done), 32'd1);
        check("R8 err pulse", 32'(seq_err), 32'd1);
        check("R8 failed step", 32'(fail_step), 32'(s));
        break;
      end

      if (s == 3) begin
        check("R7 request dropped", 32'(wr_req), 32'd0);
        check("R7 done pulse", 32'(seq_done), 32'd1);
        check("R7 no error", 32'(seq_err), 32'd0);
        check("R7 fail_step zero", 32'(fail_step), 32'd0);
      end else begin
        check("R3 next step requested", 32'(wr_req), 32'd1);
      end
    end

    @(posedge clk);
    @(negedge clk);
    check("R11 done single cycle", 32'(seq_done), 32'd0);
    check("R11 err single cycle", 32'(seq_err), 32'd0);
    check("R8 no later request", 32'(wr_req), 32'd0);
    check("R8 failed step held", 32'(fail_step), 32'(err_at));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n     = 1'b0;
    start     = 1'b0;
    freq_code = 3'd0;
    wr_done   = 1'b0;
    wr_err    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 req after reset", 32'(wr_req), 32'd0);
    check("R1 done after reset", 32'(seq_done), 32'd0);
    check("R1 err after reset", 32'(seq_err), 32'd0);
    check("R1 fail_step after reset", 32'(fail_step), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: every code, back-to-back responses
    for (int c = 0; c < 8; c++) run_seq(3'(c), 0, 0);
    // Directed: a failure on each step
    for (int e = 1; e <= 3; e++) run_seq(3'd7, e, 0);
    // Clearing after a failure by a new start
    run_seq(3'd5, 2, 2);
    run_seq(3'd3, 0, 2);

    // Random runs
    for (int n = 0; n < 200; n++) begin
      int ea;
      ea = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      run_seq(3'($urandom), ea, 4);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule